// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers thirteen level-sensitive interrupt requests, numbered 1 to 13, and presents one interrupt to the processor. The output is a 3-bit level and an 8-bit vector number. Each source has an 8-bit control byte. Bits 4:2 of that byte give the level and bits 1:0 give the priority inside the level. Together those five bits are the source's arbitration key. Bit 7 chooses between an automatically computed vector and a vector supplied for that source.

A 13-bit mask register blocks individual sources. Among the sources that are both requesting and unmasked, the one with the largest key wins. A winning key that is too small is not presented at all.

Three writable vector bytes supply the vectors for the sources that do not use the automatic vector: one for the software watchdog source and one for each of the two serial-port sources. All state is reached through a byte-wide register port. Software programs the controls, the mask and the vectors there, and can read the live request levels. The block does not handle the acknowledge cycle.

Top module: `vpic_top`

## Requirements
- R1: The pending bits read back the live request levels. Offset 0x12 returns {req[7:1], 1'b0} and offset 0x13 returns {2'b00, req[13:8]}. Writes to either offset change nothing.
- R2: Source n is active only when its request is high and mask bit n is 0. A mask bit of 1 blocks the source. Offset 0x10 holds mask bits 7:1 in data bits 7:1. Offset 0x11 holds mask bits 13:8 in data bits 5:0. After reset the mask is 0x3FFE, which blocks every source.
- R3: The winner is the active source with the largest control bits 4:0. When two keys are equal, the lower source number wins.
- R4: When the winning key is below 4, or no source is active, both out_level and out_vector are 0.
- R5: When the winner has control bit 7 set, out_vector is 24 plus the winner's control bits 4:2. out_level always equals the winner's control bits 4:2.
- R6: When the winner has control bit 7 clear, the vector comes from a source-specific place:
  - source 8 uses the watchdog vector byte at offset 0x14;
  - source 12 uses the first serial vector byte at offset 0x15;
  - source 13 uses the second serial vector byte at offset 0x16;
  - every other source gets 0x0F.
- R7: The reset values are:
  - controls 1 to 7: 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C;
  - control 8: 0x1C;
  - controls 9 to 11: 0x80;
  - controls 12 and 13: 0x00;
  - all three vector bytes: 0x0F.
- R8: Control n sits at offset n, for n from 1 to 13, and reads back all 8 bits as written. Offsets with no register read 0, and writes to them change nothing.
- R9: out_level and out_vector are registered. A request change is reflected at the first clock edge after it. A register write takes effect at the edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 13 | Request levels; bit n belongs to source n (range 13:1) |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| out_level | output | 3 | Presented interrupt level, 0 when none |
| out_vector | output | 8 | Presented vector number, 0 when none |

## Verification
A register write and a request change can land in the same cycle. The arbitration then has to pick up the new control, mask or vector byte together with the new request levels, and both must show at the output one edge later. The random phase makes this happen often: at each step it writes a random offset, including unmapped and read-only ones, and changes the request lines in the same cycle. After every step the bench compares the output pair with a bench function evaluated on its own model of the registers. Directed cases then pin the tie between equal keys, the suppression threshold, the autovector and the source-specific vectors, and the single-edge latency of a request change.

// File: rtl/vpic_pkg.sv
// Package vpic_pkg: constants shared by the interrupt controller.
// Assumes at most 15 sources, so the mask fits in two bytes.
package vpic_pkg;
    localparam logic [4:0] OFS_MASK_LO = 5'h10;
    localparam logic [4:0] OFS_MASK_HI = 5'h11;
    localparam logic [4:0] OFS_PEND_LO = 5'h12;
    localparam logic [4:0] OFS_PEND_HI = 5'h13;
    localparam logic [4:0] OFS_VEC_WD  = 5'h14;
    localparam logic [4:0] OFS_VEC_U0  = 5'h15;
    localparam logic [4:0] OFS_VEC_U1  = 5'h16;

    localparam int         SRC_WDOG    = 8;
    localparam int         SRC_UART0   = 12;
    localparam int         SRC_UART1   = 13;
    localparam logic [4:0] KEY_THRESH  = 5'd4;
    localparam logic [7:0] AUTO_BASE   = 8'd24;
    localparam logic [7:0] DEFAULT_VEC = 8'h0F;

    // Reset value of the control byte for source n.
    function automatic logic [7:0] ctrl_reset(input int n);
        if (n >= 1 && n <= 7)        return 8'(n * 4);
        else if (n == 8)             return 8'h1C;
        else if (n >= 9 && n <= 11)  return 8'h80;
        else                         return 8'h00;
    endfunction
endpackage

// File: rtl/vpic_regs.sv
// Module vpic_regs: the byte-wide register file. It holds the control
// bytes, the mask and the three vector bytes, and returns read data
// combinationally. Assumes NSRC <= 15 and an address width of 5 or more.
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NSRC = 13,
    parameter int AW   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic [NSRC:1]        req,
    output logic [NSRC:1][7:0]   ctrl_q,
    output logic [NSRC:1]        mask_q,
    output logic [7:0]           vec_wd_q,
    output logic [7:0]           vec_u0_q,
    output logic [7:0]           vec_u1_q,
    output logic [7:0]           reg_rdata
);
    logic [15:0] mask16;
    logic [15:0] pend16;

    // One control byte per source, each at its own offset.
    for (genvar g = 1; g <= NSRC; g++) begin : g_ctrl
        // Control byte register: reset value, then written at offset g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[g] <= ctrl_reset(g);
            else if (reg_wr && reg_addr == AW'(g))
                ctrl_q[g] <= reg_wdata;
        end
    end

    // Mask register: every source blocked at reset, written in two bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (reg_wr) begin
            for (int i = 1; i <= NSRC; i++) begin
                if (i < 8 && reg_addr == AW'(OFS_MASK_LO))
                    mask_q[i] <= reg_wdata[i];
                else if (i >= 8 && reg_addr == AW'(OFS_MASK_HI))
                    mask_q[i] <= reg_wdata[i-8];
            end
        end
    end

    // Vector bytes for the watchdog and the two serial sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_wd_q <= DEFAULT_VEC;
            vec_u0_q <= DEFAULT_VEC;
            vec_u1_q <= DEFAULT_VEC;
        end else if (reg_wr) begin
            if (reg_addr == AW'(OFS_VEC_WD)) vec_wd_q <= reg_wdata;
            if (reg_addr == AW'(OFS_VEC_U0)) vec_u0_q <= reg_wdata;
            if (reg_addr == AW'(OFS_VEC_U1)) vec_u1_q <= reg_wdata;
        end
    end

    // Widen the mask and the request levels to 16-bit views; bit 0 is unused.
    always_comb begin
        mask16 = '0;
        pend16 = '0;
        for (int i = 1; i <= NSRC; i++) begin
            mask16[i] = mask_q[i];
            pend16[i] = req[i];
        end
    end

    // Read mux; offsets with no register return zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 1; i <= NSRC; i++)
            if (reg_addr == AW'(i)) reg_rdata = ctrl_q[i];
        if (reg_addr == AW'(OFS_MASK_LO)) reg_rdata = mask16[7:0];
        if (reg_addr == AW'(OFS_MASK_HI)) reg_rdata = mask16[15:8];
        if (reg_addr == AW'(OFS_PEND_LO)) reg_rdata = pend16[7:0];
        if (reg_addr == AW'(OFS_PEND_HI)) reg_rdata = pend16[15:8];
        if (reg_addr == AW'(OFS_VEC_WD))  reg_rdata = vec_wd_q;
        if (reg_addr == AW'(OFS_VEC_U0))  reg_rdata = vec_u0_q;
        if (reg_addr == AW'(OFS_VEC_U1))  reg_rdata = vec_u1_q;
    end
endmodule

// File: rtl/vpic_arb.sv
// Module vpic_arb: purely combinational search for the winning source.
// The largest 5-bit key wins. The scan runs from the lowest source
// number upward and replaces the current best only on a strictly
// larger key, so a tie goes to the lower number.
module vpic_arb
    import vpic_pkg::*;
#(
    parameter int NSRC = 13,
    parameter int IDW  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]        active,
    input  logic [NSRC:1][7:0]   ctrl,
    output logic                 win_valid,
    output logic [IDW-1:0]       win_id
);
    logic [4:0] best_key;

    // Linear scan for the largest key among the active sources.
    always_comb begin
        best_key = '0;
        win_id   = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (active[i] && ctrl[i][4:0] > best_key) begin
                best_key = ctrl[i][4:0];
                win_id   = IDW'(i);
            end
        end
        win_valid = (best_key >= KEY_THRESH);
    end
endmodule

// File: rtl/vpic_vec.sv
// Module vpic_vec: forms the level and vector for the winner and
// registers them. Assumes win_id addresses a valid source whenever
// win_valid is high.
module vpic_vec
    import vpic_pkg::*;
#(
    parameter int NSRC = 13,
    parameter int IDW  = $clog2(NSRC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_valid,
    input  logic [IDW-1:0]       win_id,
    input  logic [NSRC:1][7:0]   ctrl,
    input  logic [7:0]           vec_wd,
    input  logic [7:0]           vec_u0,
    input  logic [7:0]           vec_u1,
    output logic [2:0]           out_level,
    output logic [7:0]           out_vector
);
    logic [7:0] win_ctrl;
    logic [2:0] nxt_level;
    logic [7:0] nxt_vector;

    // Pick out the winner's control byte.
    always_comb begin
        win_ctrl = '0;
        for (int i = 1; i <= NSRC; i++)
            if (win_id == IDW'(i)) win_ctrl = ctrl[i];
    end

    // Choose the autovector, a per-source vector or the default.
    always_comb begin
        nxt_level  = '0;
        nxt_vector = '0;
        if (win_valid) begin
            nxt_level = win_ctrl[4:2];
            if (win_ctrl[7])                        nxt_vector = AUTO_BASE + {5'd0, win_ctrl[4:2]};
            else if (win_id == IDW'(SRC_WDOG))      nxt_vector = vec_wd;
            else if (win_id == IDW'(SRC_UART0))     nxt_vector = vec_u0;
            else if (win_id == IDW'(SRC_UART1))     nxt_vector = vec_u1;
            else                                    nxt_vector = DEFAULT_VEC;
        end
    end

    // Output register: nothing presented during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_level  <= '0;
            out_vector <= '0;
        end else begin
            out_level  <= nxt_level;
            out_vector <= nxt_vector;
        end
    end
endmodule

// File: rtl/vpic_top.sv
// Module vpic_top: vectored priority interrupt controller. It combines
// the request levels with the mask, arbitrates among the active
// sources and registers the resulting level and vector.
// Assumes the requests are synchronous to clk.
module vpic_top #(
    parameter int NSRC = 13,
    parameter int AW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC:1]    req,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [2:0]       out_level,
    output logic [7:0]       out_vector
);
    localparam int IDW = $clog2(NSRC + 1);

    logic [NSRC:1][7:0] ctrl_q;
    logic [NSRC:1]      mask_q;
    logic [NSRC:1]      active;
    logic [7:0]         vec_wd_q, vec_u0_q, vec_u1_q;
    logic               win_valid;
    logic [IDW-1:0]     win_id;

    vpic_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .req(req), .ctrl_q(ctrl_q), .mask_q(mask_q),
        .vec_wd_q(vec_wd_q), .vec_u0_q(vec_u0_q), .vec_u1_q(vec_u1_q),
        .reg_rdata(reg_rdata)
    );

    // A source is active when it is requesting and not masked.
    always_comb active = req & ~mask_q;

    vpic_arb #(.NSRC(NSRC), .IDW(IDW)) u_arb (
        .active(active), .ctrl(ctrl_q), .win_valid(win_valid), .win_id(win_id)
    );

    vpic_vec #(.NSRC(NSRC), .IDW(IDW)) u_vec (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_id(win_id),
        .ctrl(ctrl_q), .vec_wd(vec_wd_q), .vec_u0(vec_u0_q), .vec_u1(vec_u1_q),
        .out_level(out_level), .out_vector(out_vector)
    );
endmodule

// File: rtl/vpic_chk.sv
// Module vpic_chk: temporal checks on the interrupt controller, bound
// to every instance of vpic_top.
module vpic_chk #(
    parameter int NSRC = 13,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC:1]   req,
    input logic [NSRC:1]   mask_q,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [7:0]      reg_wdata,
    input logic [2:0]      out_level,
    input logic [7:0]      out_vector
);
    // R4: with no interrupt presented, the vector is zero as well.
    a_r4_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_level == 3'd0) |-> (out_vector == 8'd0));

    // R2: when every request is masked, nothing is presented one edge later.
    a_r2_masked_none: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & ~mask_q) == '0) |=> (out_level == 3'd0));

    // R9: a presented level needs a request at the edge before.
    a_r9_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (out_level != 3'd0) |-> ($past(req) != '0));

    // R2: a write to the low mask byte lands in mask bits 7:1.
    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(5'h10)) |=> (mask_q[7:1] == $past(reg_wdata[7:1])));
endmodule

bind vpic_top vpic_chk #(.NSRC(NSRC), .AW(AW)) u_vpic_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .mask_q(mask_q), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .out_level(out_level),
    .out_vector(out_vector)
);

// File: tb/test_vpic_top.sv
// Bench test_vpic_top: directed corner cases plus seeded random writes
// and request changes, compared against a register model kept in the bench.
module test_vpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] req = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [2:0]  out_level;
    logic [7:0]  out_vector;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  m_ctrl [1:13];
    logic [13:1] m_mask;
    logic [7:0]  m_wd, m_u0, m_u1;

    vpic_top i_vpic_top (
        .clk(clk), .rst_n(rst_n), .req(req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_level(out_level),
        .out_vector(out_vector)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Record one comparison and report it if it fails.
    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Put the bench model into its reset state.
    task automatic model_reset();
        for (int i = 1; i <= 13; i++) begin
            if (i <= 7)      m_ctrl[i] = 8'(i * 4);
            else if (i == 8) m_ctrl[i] = 8'h1C;
            else if (i <= 11) m_ctrl[i] = 8'h80;
            else             m_ctrl[i] = 8'h00;
        end
        m_mask = '1;
        m_wd = 8'h0F; m_u0 = 8'h0F; m_u1 = 8'h0F;
    endtask

    // Expected output pair {level, vector} for request levels r.
    function automatic logic [10:0] expect_out(input logic [13:1] r);
        logic [4:0] bk;
        int         bi;
        logic [7:0] c, v;
        bk = 0; bi = 0;
        for (int i = 1; i <= 13; i++)
            if (r[i] && !m_mask[i] && m_ctrl[i][4:0] > bk) begin
                bk = m_ctrl[i][4:0];
                bi = i;
            end
        if (bk < 5'd4) return '0;
        c = m_ctrl[bi];
        if (c[7])          v = 8'd24 + {5'd0, c[4:2]};
        else if (bi == 8)  v = m_wd;
        else if (bi == 12) v = m_u0;
        else if (bi == 13) v = m_u1;
        else               v = 8'h0F;
        return {c[4:2], v};
    endfunction

    // Expected read data at offset a.
    function automatic logic [7:0] expect_rd(input logic [4:0] a, input logic [13:1] r);
        if (a >= 5'd1 && a <= 5'd13) return m_ctrl[a];
        case (a)
            5'h10: return {m_mask[7:1], 1'b0};
            5'h11: return {2'b00, m_mask[13:8]};
            5'h12: return {r[7:1], 1'b0};
            5'h13: return {2'b00, r[13:8]};
            5'h14: return m_wd;
            5'h15: return m_u0;
            5'h16: return m_u1;
            default: return 8'h00;
        endcase
    endfunction

    // Apply a write to the bench model.
    task automatic model_write(input logic [4:0] a, input logic [7:0] d);
        if (a >= 5'd1 && a <= 5'd13) m_ctrl[a] = d;
        else if (a == 5'h10) m_mask[7:1] = d[7:1];
        else if (a == 5'h11) m_mask[13:8] = d[5:0];
        else if (a == 5'h14) m_wd = d;
        else if (a == 5'h15) m_u0 = d;
        else if (a == 5'h16) m_u1 = d;
    endtask

    // Write one register: driven at a negedge, held over one posedge.
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        model_write(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Read one register at a negedge and compare it with the model.
    task automatic rd_check(input string tag, input logic [4:0] a);
        reg_addr = a;
        #1;
        check(tag, {8'h0, reg_rdata}, {8'h0, expect_rd(a, req)});
    endtask

    // Compare the output pair with the model.
    task automatic out_check(input string tag);
        check(tag, {5'h0, out_level, out_vector}, {5'h0, expect_out(req)});
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 / R8: every offset reads its reset value.
        for (int a = 0; a < 24; a++) rd_check("R7 R8 reset read", 5'(a));
        out_check("R7 reset output");

        // R2: everything requested but masked at reset.
        req = '1;
        @(negedge clk); @(negedge clk);
        check("R2 all masked", {13'h0, out_level}, 16'h0);
        rd_check("R1 pending lo", 5'h12);
        rd_check("R1 pending hi", 5'h13);

        // R1 / R8: writes to pending and unmapped offsets change nothing.
        wr(5'h12, 8'hFF); wr(5'h13, 8'hFF); wr(5'h1F, 8'hAA);
        rd_check("R1 pending after write", 5'h12);
        rd_check("R8 unmapped read", 5'h1F);

        // R3: equal keys on sources 4 and 6, lower number wins.
        req = '0;
        wr(5'd4, 8'h12); wr(5'd6, 8'h12);
        wr(5'h10, 8'h00); wr(5'h11, 8'h00);
        @(negedge clk);
        req[4] = 1'b1; req[6] = 1'b1;
        // R9: the request change shows at the first edge.
        @(negedge clk);
        out_check("R9 one-edge latency");
        check("R3 tie lowest level", {13'h0, out_level}, 16'd4);
        check("R3 tie lowest vector", {8'h0, out_vector}, 16'h0F);
        req[4] = 1'b0;
        @(negedge clk);
        out_check("R3 single winner");

        // R4: key 3 is suppressed, key 4 is presented.
        req = '0;
        wr(5'd2, 8'h03);
        req[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R4 below threshold", {5'h0, out_level, out_vector}, 16'h0);
        wr(5'd2, 8'h04);
        @(negedge clk);
        check("R4 at threshold", {5'h0, out_level, out_vector}, {5'h0, 3'd1, 8'h0F});

        // R5: autovector on source 9.
        wr(5'd9, 8'h9C);
        req[9] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R5 autovector", {5'h0, out_level, out_vector}, {5'h0, 3'd7, 8'd31});

        // R6: source-specific vectors for sources 8, 12 and 13.
        req = '0;
        wr(5'h14, 8'h40); wr(5'h15, 8'h41); wr(5'h16, 8'h42);
        wr(5'd12, 8'h08); wr(5'd13, 8'h0C);
        req[8] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R6 watchdog vector", {8'h0, out_vector}, 16'h40);
        req = '0; req[12] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R6 uart0 vector", {8'h0, out_vector}, 16'h41);
        req = '0; req[13] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R6 uart1 vector", {8'h0, out_vector}, 16'h42);

        // R2 / R3 / R5 / R6 / R8 / R9: writes and request changes in the same cycle.
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < 3000; k++) begin
            logic [4:0] a;
            logic [7:0] d;
            a = 5'($urandom_range(0, 23));
            d = 8'($urandom);
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
            model_write(a, d);
            req = 13'($urandom) & 13'($urandom);
            @(negedge clk);
            reg_wr = 1'b0;
            @(negedge clk);
            out_check("R3 R5 R6 random output");
            rd_check("R8 random read", 5'($urandom_range(0, 23)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule